// File: doc/BRIEF.md
# Serial Port with Selectable Transmit-Interrupt Timing

This block is a full-duplex asynchronous serial port. A host reaches it through a byte-wide register bus that has two locations. The control/status location sets the character format, enables the receiver and the transmitter, selects when the transmit interrupt fires, and carries a sticky receive-error flag. The data location takes bytes to transmit on a write and returns the last received byte on a read.

The port does not contain a baud generator. Two externally generated ticks arrive at the block, and a select input picks one of them as the 16x oversampling tick. A transmitted bit lasts 16 selected ticks. The receiver finds the start bit on a falling edge of the line and then samples every later bit near its middle.

The transmitter has a holding register followed by a shift register. It raises its interrupt in one of two modes. In end-of-byte mode the interrupt is high as soon as the holding register is free. In end-of-message mode it is high only once the holding register and the shift register are both empty. Clearing the transmitter enable also drops the block back to end-of-byte mode.

Top module: `sio_port`

## Requirements
- R1: After reset the control/status location (address 0) reads 0x00, `txd` is 1, and `tx_irq` and `rx_irq` are 0.
- R2: Control bits: bit0 transmitter enable, bit1 end-of-message interrupt mode, bit2 8-bit characters (clear = 7-bit), bit3 parity enable, bit4 even parity (clear = odd), bit5 receiver enable, bit6 software semaphore. Bits 6..2 and bit0 read back as written. Bit6 has no effect on the line or the interrupts.
- R3: Any write to address 0 with bit0 = 0 leaves bit1 at 0, whatever value is written to bit1.
- R4: A transmitted frame is, in line order: a start bit of 0, the data LSB first (7 or 8 bits), a parity bit if enabled (even parity makes the number of ones in data plus parity even), and a stop bit of 1. Each bit lasts 16 selected ticks.
- R5: While bit0 is 0, `txd` stays 1, `tx_irq` stays 0, and writes to address 1 are discarded.
- R6: With bit0 = 1 and bit1 = 0, `tx_irq` is high whenever the holding register is empty. A byte written to address 1 moves into the shift register at once when the shifter is idle.
- R7: With bit1 = 1, `tx_irq` is high only when both the holding register and the shift register are empty.
- R8: When bit5 is 1, a received frame sets `rx_irq`. A read of address 1 returns the byte (bit7 = 0 in 7-bit mode) and clears `rx_irq`.
- R9: While bit5 is 0, frames on `rxd` are ignored and `rx_irq` stays low.
- R10: Bit7 (receive error) is set by a parity mismatch, by a stop bit sampled as 0, or by a frame that completes while the previous byte is still unread.
- R11: Writing 1 to bit7 clears the error flag. Writing 0 to bit7 leaves it unchanged.
- R12: With `tick_sel` = 0 the port runs from `tick_a`; with `tick_sel` = 1 it runs from `tick_b`. The unselected tick has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = control/status, 1 = data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed location |
| tick_a | input | 1 | First 16x oversampling tick |
| tick_b | input | 1 | Second 16x oversampling tick |
| tick_sel | input | 1 | Tick choice: 0 = tick_a, 1 = tick_b |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idles at 1 |
| tx_irq | output | 1 | Transmit interrupt, level |
| rx_irq | output | 1 | Received byte waiting, level |

## Verification
On every cycle the assertions check the following:
- `txd` stays high and the transmit interrupt stays low while the transmitter is disabled.
- Whenever the interrupt is high in end-of-message mode, the shifter and the holding register are both empty.
- After a write with bit0 clear, the mode bit reads 0.
- The error flag follows its set and write-1-to-clear rules.
- A data read empties the receive buffer.
- A disabled receiver never completes a frame.

Some behaviour needs the bench scenarios because it spans whole frames:
- The bit order, the parity value and the stop bit on the line, across the 7/8-bit and parity settings.
- Receive data returned through loopback.
- Overrun, framing and parity errors.
- A stalled tick that freezes the transmitter.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;

  localparam int FRAME_W = 11;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;

  // control/status layout, bit7 down to bit0
  typedef struct packed {
    logic err;
    logic sem;
    logic rx_en;
    logic par_even;
    logic par_en;
    logic eight;
    logic eom;
    logic tx_en;
  } ctrl_t;

  // character with the unused top bit zeroed in 7-bit mode
  function automatic logic [7:0] mask_char(input logic [7:0] d, input logic eight);
    return eight ? d : {1'b0, d[6:0]};
  endfunction

  // parity bit value making the total ones count even (or odd)
  function automatic logic par_bit(input logic [7:0] d, input logic even);
    return even ? ^d : ~(^d);
  endfunction

  // number of bit slots on the line, start and stop included
  function automatic logic [3:0] frame_len(input logic eight, input logic par_en);
    return 4'd9 + {3'b000, eight} + {3'b000, par_en};
  endfunction

  // line bits, index 0 goes out first; unused upper slots are idle ones
  function automatic logic [FRAME_W-1:0] frame_bits(input logic [7:0] d, input logic eight,
                                                    input logic par_en, input logic even);
    logic [FRAME_W-1:0] f;
    logic [7:0] m;
    m = mask_char(d, eight);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 7; i++) f[i+1] = m[i];
    if (eight) f[8] = m[7];
    if (par_en) begin
      if (eight) f[9] = par_bit(m, even);
      else       f[8] = par_bit(m, even);
    end
    return f;
  endfunction

endpackage

// File: rtl/sio_regs.sv
`timescale 1ns/1ps
module sio_regs
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       err_set,
  input  logic [7:0] rx_data,
  output ctrl_t      ctrl,
  output logic [7:0] bus_rdata,
  output logic       wr_ctrl,
  output logic       wr_data,
  output logic       rd_data
);

  assign wr_ctrl = bus_sel &  bus_wr & ~bus_addr;
  assign wr_data = bus_sel &  bus_wr &  bus_addr;
  assign rd_data = bus_sel & ~bus_wr &  bus_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl.tx_en    <= bus_wdata[0];
        ctrl.eom      <= bus_wdata[1] & bus_wdata[0];
        ctrl.eight    <= bus_wdata[2];
        ctrl.par_en   <= bus_wdata[3];
        ctrl.par_even <= bus_wdata[4];
        ctrl.rx_en    <= bus_wdata[5];
        ctrl.sem      <= bus_wdata[6];
      end
      // a hardware error event wins over a clear in the same cycle
      if (err_set)
        ctrl.err <= 1'b1;
      else if (wr_ctrl && bus_wdata[7])
        ctrl.err <= 1'b0;
    end
  end

  assign bus_rdata = bus_addr ? rx_data : ctrl;

endmodule

// File: rtl/sio_tx.sv
`timescale 1ns/1ps
module sio_tx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       eight,
  input  logic       par_en,
  input  logic       par_even,
  output logic       txd,
  output logic       thr_full,
  output logic       busy
);

  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  logic [7:0]         thr;
  logic [FRAME_W-1:0] shreg;
  logic [3:0]         left;
  logic [CW-1:0]      cnt;
  logic               load;

  assign load = thr_full & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
      shreg    <= '1;
      left     <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
    end else if (!en) begin
      thr_full <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      shreg    <= '1;
    end else begin
      if (load) begin
        shreg    <= frame_bits(thr, eight, par_en, par_even);
        left     <= frame_len(eight, par_en);
        cnt      <= '0;
        busy     <= 1'b1;
        thr_full <= 1'b0;
      end else if (busy && tick) begin
        if (cnt == LAST) begin
          cnt   <= '0;
          shreg <= {1'b1, shreg[FRAME_W-1:1]};
          left  <= left - 4'd1;
          if (left == 4'd1) busy <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (wr) begin
        thr      <= wdata;
        thr_full <= 1'b1;
      end
    end
  end

  assign txd = (en && busy) ? shreg[0] : 1'b1;

endmodule

// File: rtl/sio_rx.sv
`timescale 1ns/1ps
module sio_rx
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       rxd,
  input  logic       eight,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       rd_ack,
  output logic [7:0] data,
  output logic       full,
  output logic       done,
  output logic       err
);

  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF = CW'(OVS / 2 - 1);

  rx_state_e     st;
  logic          s1, s2, prev;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic          pbit;
  logic          fall, bit_end;
  logic [7:0]    captured;
  logic [2:0]    last_idx;

  assign fall     = prev & ~s2;
  assign bit_end  = tick && (cnt == LAST);
  assign last_idx = eight ? 3'd7 : 3'd6;
  assign captured = eight ? sh : {1'b0, sh[7:1]};
  assign done     = en && (st == RX_STOP) && bit_end;

  always_comb begin
    err = 1'b0;
    if (done) begin
      if (!s2) err = 1'b1;
      if (par_en && (pbit != par_bit(captured, par_even))) err = 1'b1;
      if (full && !rd_ack) err = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      prev <= 1'b1;
      st   <= RX_IDLE;
      cnt  <= '0;
      idx  <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      data <= '0;
      full <= 1'b0;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      prev <= s2;
      if (rd_ack) full <= 1'b0;
      if (done) begin
        data <= captured;
        full <= 1'b1;
      end
      if (!en) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          RX_IDLE: begin
            if (fall) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            if (tick) begin
              if (cnt == HALF) begin
                cnt <= '0;
                idx <= '0;
                st  <= s2 ? RX_IDLE : RX_DATA;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          RX_DATA: begin
            if (bit_end) begin
              cnt <= '0;
              sh  <= {s2, sh[7:1]};
              idx <= idx + 3'd1;
              if (idx == last_idx) st <= par_en ? RX_PAR : RX_STOP;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (bit_end) begin
              cnt  <= '0;
              pbit <= s2;
              st   <= RX_STOP;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (bit_end) begin
              cnt <= '0;
              st  <= RX_IDLE;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sio_port.sv
`timescale 1ns/1ps
module sio_port
  import sio_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tick_a,
  input  logic       tick_b,
  input  logic       tick_sel,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_irq,
  output logic       rx_irq
);

  ctrl_t      ctrl_q;
  logic       tick;
  logic       wr_ctrl, wr_data, rd_data;
  logic       thr_full, tx_busy;
  logic [7:0] rx_byte;
  logic       rx_full, rx_done, err_set;
  logic       cfg_tx_en, cfg_eom, cfg_rx_en, cfg_err;

  assign tick      = tick_sel ? tick_b : tick_a;
  assign cfg_tx_en = ctrl_q.tx_en;
  assign cfg_eom   = ctrl_q.eom;
  assign cfg_rx_en = ctrl_q.rx_en;
  assign cfg_err   = ctrl_q.err;

  sio_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .err_set   (err_set),
    .rx_data   (rx_byte),
    .ctrl      (ctrl_q),
    .bus_rdata (bus_rdata),
    .wr_ctrl   (wr_ctrl),
    .wr_data   (wr_data),
    .rd_data   (rd_data)
  );

  sio_tx #(.OVS(OVS)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (cfg_tx_en),
    .wr       (wr_data),
    .wdata    (bus_wdata),
    .eight    (ctrl_q.eight),
    .par_en   (ctrl_q.par_en),
    .par_even (ctrl_q.par_even),
    .txd      (txd),
    .thr_full (thr_full),
    .busy     (tx_busy)
  );

  sio_rx #(.OVS(OVS)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .en       (cfg_rx_en),
    .rxd      (rxd),
    .eight    (ctrl_q.eight),
    .par_en   (ctrl_q.par_en),
    .par_even (ctrl_q.par_even),
    .rd_ack   (rd_data),
    .data     (rx_byte),
    .full     (rx_full),
    .done     (rx_done),
    .err      (err_set)
  );

  // end-of-message mode additionally waits for the shifter to drain
  assign tx_irq = cfg_tx_en & ~thr_full & (~cfg_eom | ~tx_busy);
  assign rx_irq = rx_full;

endmodule

// File: rtl/sio_port_chk.sv
`timescale 1ns/1ps
module sio_port_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_ctrl,
  input logic rd_data,
  input logic wd_en,
  input logic wd_err,
  input logic txd,
  input logic tx_irq,
  input logic tx_en,
  input logic eom,
  input logic rx_en,
  input logic err_flag,
  input logic thr_full,
  input logic tx_busy,
  input logic rx_full,
  input logic rx_done,
  input logic err_set
);

  AST_TXD_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> txd);                                          // R5
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_irq);                                      // R5
  AST_EOM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wd_en) |=> !eom);                            // R3
  AST_EOM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq && eom) |-> (!tx_busy && !thr_full));             // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> err_flag);                                    // R10
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wd_err && !err_set) |=> !err_flag);           // R11
  AST_RX_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rx_done) |=> !rx_full);                      // R8
  AST_RX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !rx_done);                                     // R9

endmodule

bind sio_port sio_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_ctrl  (wr_ctrl),
  .rd_data  (rd_data),
  .wd_en    (bus_wdata[0]),
  .wd_err   (bus_wdata[7]),
  .txd      (txd),
  .tx_irq   (tx_irq),
  .tx_en    (cfg_tx_en),
  .eom      (cfg_eom),
  .rx_en    (cfg_rx_en),
  .err_flag (cfg_err),
  .thr_full (thr_full),
  .tx_busy  (tx_busy),
  .rx_full  (rx_full),
  .rx_done  (rx_done),
  .err_set  (err_set)
);

// File: tb/sim_sio_port.sv
`timescale 1ns/1ps
module sim_sio_port;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;
  // {control, data}; control carries rx enable and tx enable for loopback
  localparam logic [15:0] VEC [6] = '{16'h25A5, 16'h21C3, 16'h2D3C,
                                      16'h3D3C, 16'h397F, 16'h2900};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick_a = 1'b1, tick_b = 1'b0, tick_sel = 1'b0;
  logic       rxd, rxd_drv = 1'b1, loop_en = 1'b0;
  logic       txd, tx_irq, rx_irq;
  int         checks = 0, errors = 0;
  bit         finished = 1'b0;

  assign rxd = loop_en ? txd : rxd_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_a(tick_a), .tick_b(tick_b), .tick_sel(tick_sel),
    .rxd(rxd), .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // expected line bits built by counting ones
  function automatic logic [10:0] exp_frame(input logic [7:0] cfg, input logic [7:0] d,
                                            output int len);
    logic [10:0] f;
    int nd, ones, k;
    f = '1;
    f[0] = 1'b0;
    nd = cfg[2] ? 8 : 7;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      f[1+i] = d[i];
      if (d[i]) ones++;
    end
    k = 1 + nd;
    if (cfg[3]) begin
      f[k] = cfg[4] ? ((ones % 2) == 1) : ((ones % 2) == 0);
      k++;
    end
    f[k] = 1'b1;
    len = k + 1;
    return f;
  endfunction

  task automatic capture(input int len, output logic [10:0] got, output bit seen);
    int waited;
    got = '1;
    seen = 1'b0;
    waited = 0;
    while (!seen && waited < 400) begin
      @(negedge clk);
      if (txd == 1'b0) seen = 1'b1;
      waited++;
    end
    if (seen) begin
      repeat (8) @(negedge clk);
      got[0] = txd;
      for (int i = 1; i < len; i++) begin
        repeat (16) @(negedge clk);
        got[i] = txd;
      end
    end
  endtask

  task automatic send_rx(input logic [10:0] bits, input int len);
    for (int i = 0; i < len; i++) begin
      rxd_drv = bits[i];
      repeat (16) @(negedge clk);
    end
    rxd_drv = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=expired expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  v, c, d;
    logic [10:0] got, expf;
    int          len, lows;
    bit          seen;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(1'b0, v);
    chk(v == 8'h00, "R1 control after reset", v, 8'h00);
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk(tx_irq == 1'b0, "R1 tx_irq", tx_irq, 0);
    chk(rx_irq == 1'b0, "R1 rx_irq", rx_irq, 0);

    // R4 / R8 vector table through loopback
    loop_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      c = VEC[k][15:8];
      d = VEC[k][7:0];
      bus_write(1'b0, c);
      bus_write(1'b1, d);
      expf = exp_frame(c, d, len);
      capture(len, got, seen);
      chk(seen && got == expf, $sformatf("R4 frame vector %0d", k), got, expf);
      repeat (30) @(negedge clk);
      chk(rx_irq == 1'b1, $sformatf("R8 rx_irq vector %0d", k), rx_irq, 1);
      bus_read(1'b1, v);
      chk(v == (c[2] ? d : {1'b0, d[6:0]}), $sformatf("R8 rx data vector %0d", k), v,
          c[2] ? d : {1'b0, d[6:0]});
      chk(rx_irq == 1'b0, $sformatf("R8 rx_irq cleared vector %0d", k), rx_irq, 0);
      bus_read(1'b0, v);
      chk(v == c, $sformatf("R10 no error vector %0d", k), v, c);
    end
    loop_en = 1'b0;

    // R2 / R3 control layout and mode auto-clear
    bus_write(1'b0, 8'h03);
    bus_read(1'b0, v);
    chk(v == 8'h03, "R2 readback tx_en+eom", v, 8'h03);
    bus_write(1'b0, 8'h02);
    bus_read(1'b0, v);
    chk(v == 8'h00, "R3 eom cleared with tx_en=0", v, 8'h00);
    bus_write(1'b0, 8'h7E);
    bus_read(1'b0, v);
    chk(v == 8'h7C, "R3 eom cleared in full write", v, 8'h7C);
    bus_write(1'b0, 8'h40);
    repeat (20) @(negedge clk);
    chk(txd == 1'b1 && tx_irq == 1'b0, "R2 semaphore no effect", {txd, tx_irq}, 2'b10);

    // R5 transmitter disabled
    bus_write(1'b0, 8'h04);
    bus_write(1'b1, 8'h00);
    lows = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd == 1'b0 || tx_irq) lows++;
    end
    chk(lows == 0, "R5 txd high / irq low while disabled", lows, 0);
    bus_write(1'b0, 8'h05);
    repeat (3) @(negedge clk);
    chk(tx_irq == 1'b1, "R5 holding empty after dropped write", tx_irq, 1);
    lows = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk(lows == 0, "R5 dropped write never sent", lows, 0);

    // R6 end-of-byte interrupt
    bus_write(1'b1, 8'h81);
    chk(tx_irq == 1'b0, "R6 irq low while holding full", tx_irq, 0);
    repeat (5) @(negedge clk);
    chk(tx_irq == 1'b1, "R6 irq high once byte moved to shifter", tx_irq, 1);
    repeat (220) @(negedge clk);

    // R7 end-of-message interrupt
    bus_write(1'b0, 8'h07);
    bus_write(1'b1, 8'h81);
    repeat (5) @(negedge clk);
    chk(tx_irq == 1'b0, "R7 irq low while shifter busy", tx_irq, 0);
    repeat (200) @(negedge clk);
    chk(tx_irq == 1'b1, "R7 irq high after frame drained", tx_irq, 1);

    // R12 tick selection: tick_a stalled, tick_b running but unselected
    tick_a = 1'b0; tick_b = 1'b1; tick_sel = 1'b0;
    bus_write(1'b1, 8'hFF);
    repeat (100) @(negedge clk);
    chk(txd == 1'b0 && tx_irq == 1'b0, "R12 frame frozen without selected tick",
        {txd, tx_irq}, 2'b00);
    tick_sel = 1'b1;
    repeat (300) @(negedge clk);
    chk(txd == 1'b1 && tx_irq == 1'b1, "R12 frame completes on tick_b", {txd, tx_irq}, 2'b11);
    tick_a = 1'b1; tick_b = 1'b0; tick_sel = 1'b0;

    // R9 receiver disabled ignores loopback frame
    loop_en = 1'b1;
    bus_write(1'b0, 8'h05);
    bus_write(1'b1, 8'h12);
    repeat (230) @(negedge clk);
    chk(rx_irq == 1'b0, "R9 rx disabled ignores frame", rx_irq, 0);
    loop_en = 1'b0;

    // R10 parity mismatch: receiver odd, frame sent with even parity
    bus_write(1'b0, 8'h2C);
    expf = exp_frame(8'h3C, 8'h01, len);
    send_rx(expf, len);
    repeat (30) @(negedge clk);
    bus_read(1'b0, v);
    chk(v == 8'hAC, "R10 parity error flag", v, 8'hAC);
    // R11 write 0 keeps, write 1 clears
    bus_write(1'b0, 8'h2C);
    bus_read(1'b0, v);
    chk(v == 8'hAC, "R11 write 0 keeps error", v, 8'hAC);
    bus_write(1'b0, 8'hAC);
    bus_read(1'b0, v);
    chk(v == 8'h2C, "R11 write 1 clears error", v, 8'h2C);
    bus_read(1'b1, v);

    // R10 missing stop bit
    bus_write(1'b0, 8'h24);
    expf = exp_frame(8'h24, 8'h5A, len);
    expf[9] = 1'b0;
    send_rx(expf, len);
    repeat (30) @(negedge clk);
    bus_read(1'b0, v);
    chk(v == 8'hA4, "R10 framing error flag", v, 8'hA4);
    bus_write(1'b0, 8'hA4);
    bus_read(1'b1, v);
    chk(v == 8'h5A, "R8 data kept on framing error", v, 8'h5A);

    // R10 overrun
    expf = exp_frame(8'h24, 8'h11, len);
    send_rx(expf, len);
    repeat (30) @(negedge clk);
    bus_read(1'b0, v);
    chk(v == 8'h24, "R10 first byte no error", v, 8'h24);
    expf = exp_frame(8'h24, 8'h22, len);
    send_rx(expf, len);
    repeat (30) @(negedge clk);
    bus_read(1'b0, v);
    chk(v == 8'hA4, "R10 overrun error flag", v, 8'hA4);
    bus_read(1'b1, v);
    chk(v == 8'h22, "R8 newest byte after overrun", v, 8'h22);

    finished = 1'b1;
    finish_run();
  end

endmodule